// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This block holds the atomic reservation for the load-linked and store-conditional pair of a processor core. A load-linked saves its address and raises a link flag. A later store-conditional is first judged locally. The local check passes when the flag is still up and the store falls in the same cache line as the saved address. The flag drops on a snoop or write hit to the linked line, on an exception-return pulse, and after every store-conditional.

When the external interface is enabled, every load-linked is announced on a bus-side notification pulse. A store-conditional that passes the local check becomes a request to system logic, which answers with an acknowledge and a one-bit grant. The core receives a one-cycle done pulse with a success bit, and may write memory only on success. Because the system logic takes part in the verdict, the pair can work between processors that share memory without full cache coherency. When the interface is disabled, a load-linked shows nothing outside, and the local check alone decides.

Top module: `llsc_resv_unit`

## Requirements
- R1: After reset the link flag is clear and every output (ext_ll_req_o, ext_ll_addr_o, ext_sc_req_o, ext_sc_addr_o, sc_done_o, sc_success_o) is 0.
- R2: An accepted load-linked sets the link flag and saves its address. Addresses are compared by line: the low log2(LINE_BYTES) bits (5 by default) are ignored, so a store-conditional at any offset of the linked line passes the local check.
- R3: With EXT_EN=1, an accepted load-linked drives ext_ll_req_o high for exactly the next cycle, with its address on ext_ll_addr_o. With EXT_EN=0, ext_ll_req_o stays 0.
- R4: With EXT_EN=1, a store-conditional that passes the local check raises ext_sc_req_o in the next cycle, with its address on ext_sc_addr_o. The request stays high until ext_sc_ack_i is sampled high, and it is low in the cycle after that.
- R5: In the cycle after the acknowledge is sampled, sc_done_o pulses for one cycle and sc_success_o equals the ext_sc_grant_i sampled with the acknowledge. sc_success_o is never high without sc_done_o.
- R6: A store-conditional that fails the local check (flag clear or a different line) produces sc_done_o=1 and sc_success_o=0 in the next cycle, and no external request.
- R7: The link flag clears on inval_valid_i to the linked line, on eret_i, and on any accepted store-conditional. An invalidation to another line has no effect. A clearing event in the same cycle as a store-conditional makes that store-conditional fail.
- R8: A load-linked in the same cycle as an invalidation or eret_i still sets the flag. A store-conditional and a load-linked in the same cycle: the store-conditional is handled and the load-linked is ignored.
- R9: While ext_sc_req_o is high, new load-linked and store-conditional inputs are ignored and sc_done_o stays 0. An acknowledge while no request is pending has no effect.
- R10: With EXT_EN=0, a store-conditional that passes the local check gives sc_done_o=1 and sc_success_o=1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid_i | input | 1 | Load-linked executes this cycle |
| ll_addr_i | input | ADDR_W | Load-linked address |
| sc_valid_i | input | 1 | Store-conditional executes this cycle |
| sc_addr_i | input | ADDR_W | Store-conditional address |
| inval_valid_i | input | 1 | Snoop or write hit seen this cycle |
| inval_addr_i | input | ADDR_W | Address of the snoop or write hit |
| eret_i | input | 1 | Exception-return pulse |
| ext_ll_req_o | output | 1 | One-cycle notification of a load-linked |
| ext_ll_addr_o | output | ADDR_W | Address carried by the notification |
| ext_sc_req_o | output | 1 | Store-conditional request, held until acknowledged |
| ext_sc_addr_o | output | ADDR_W | Address of the pending store-conditional |
| ext_sc_ack_i | input | 1 | System logic answers the request |
| ext_sc_grant_i | input | 1 | 1 = go, 0 = no-go, valid with the acknowledge |
| sc_done_o | output | 1 | One-cycle store-conditional completion pulse |
| sc_success_o | output | 1 | Store-conditional succeeded, valid with done |

## Verification
The assertions check the request handshake on every cycle: a request holds until it is acknowledged, it drops after the acknowledge, done follows with the granted verdict, no completion appears while a request waits, and the flag responds to load-linked and exception return. Line-granular matching, invalidations by address, the same-cycle priorities and the behaviour with the interface disabled are shown by the bench. It runs a reference model against both an enabled and a disabled instance, with directed corner cases and random operation mixes over a few lines.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_WAIT = 1'b1
  } sc_state_t;

endpackage

// File: rtl/llsc_line_cmp.sv
module llsc_line_cmp #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic              same_line_o
);
  localparam int OFS_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 0;
  localparam int TAG_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] diff;
  assign diff = a_i ^ b_i;

  generate
    if (OFS_W == 0) begin : g_full
      assign same_line_o = (diff == '0);
    end else begin : g_masked
      localparam logic [ADDR_W-1:0] LINE_MASK = {{TAG_W{1'b1}}, {OFS_W{1'b0}}};
      assign same_line_o = ((diff & LINE_MASK) == '0);
    end
  endgenerate
endmodule

// File: rtl/llsc_link_reg.sv
module llsc_link_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              clr_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
    end else if (set_i) begin
      vld_o  <= 1'b1;
      addr_o <= set_addr_i;
    end else if (clr_i) begin
      vld_o  <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> vld_o) else $error("link set lost"); // R8
endmodule

// File: rtl/llsc_sc_ctrl.sv
module llsc_sc_ctrl
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter bit EXT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sc_valid_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  input  logic              local_ok_i,
  input  logic              ack_i,
  input  logic              grant_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              done_o,
  output logic              success_o
);
  sc_state_t state;

  assign busy_o = (state == SC_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SC_IDLE;
      req_o      <= 1'b0;
      req_addr_o <= '0;
      done_o     <= 1'b0;
      success_o  <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      success_o <= 1'b0;
      case (state)
        SC_IDLE: begin
          if (sc_valid_i) begin
            if (local_ok_i && EXT_EN) begin
              state      <= SC_WAIT;
              req_o      <= 1'b1;
              req_addr_o <= sc_addr_i;
            end else begin
              done_o    <= 1'b1;
              success_o <= local_ok_i;
            end
          end
        end
        SC_WAIT: begin
          if (ack_i) begin
            state     <= SC_IDLE;
            req_o     <= 1'b0;
            done_o    <= 1'b1;
            success_o <= grant_i;
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> (req_o && $stable(req_addr_o))) else $error("request dropped"); // R4
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (req_o && ack_i) |=> (!req_o && done_o)) else $error("no release after ack"); // R5
  AST_VERDICT: assert property (@(posedge clk) disable iff (rst)
    (req_o && ack_i) |=> (success_o == $past(grant_i))) else $error("verdict mismatch"); // R5
  AST_SUCC_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    success_o |-> done_o) else $error("success without done"); // R5
  AST_QUIET_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    req_o |-> !done_o) else $error("done while waiting"); // R9
endmodule

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter bit EXT_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ll_valid_i,
  input  logic [ADDR_W-1:0] ll_addr_i,
  input  logic              sc_valid_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  input  logic              inval_valid_i,
  input  logic [ADDR_W-1:0] inval_addr_i,
  input  logic              eret_i,
  output logic              ext_ll_req_o,
  output logic [ADDR_W-1:0] ext_ll_addr_o,
  output logic              ext_sc_req_o,
  output logic [ADDR_W-1:0] ext_sc_addr_o,
  input  logic              ext_sc_ack_i,
  input  logic              ext_sc_grant_i,
  output logic              sc_done_o,
  output logic              sc_success_o
);
  logic              busy;
  logic              ll_take, sc_take;
  logic              link_vld;
  logic [ADDR_W-1:0] link_addr;
  logic              sc_same, inv_same;
  logic              inv_hit, local_ok, link_clr;

  assign sc_take  = sc_valid_i && !busy;
  assign ll_take  = ll_valid_i && !busy && !sc_valid_i;
  assign inv_hit  = inval_valid_i && inv_same;
  assign local_ok = link_vld && sc_same && !eret_i && !inv_hit;
  assign link_clr = sc_take || eret_i || inv_hit;

  llsc_line_cmp #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_cmp_sc (
    .a_i(sc_addr_i), .b_i(link_addr), .same_line_o(sc_same));

  llsc_line_cmp #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_cmp_inv (
    .a_i(inval_addr_i), .b_i(link_addr), .same_line_o(inv_same));

  llsc_link_reg #(.ADDR_W(ADDR_W)) u_link (
    .clk(clk), .rst(rst),
    .set_i(ll_take), .set_addr_i(ll_addr_i), .clr_i(link_clr),
    .vld_o(link_vld), .addr_o(link_addr));

  llsc_sc_ctrl #(.ADDR_W(ADDR_W), .EXT_EN(EXT_EN)) u_ctrl (
    .clk(clk), .rst(rst),
    .sc_valid_i(sc_valid_i), .sc_addr_i(sc_addr_i), .local_ok_i(local_ok),
    .ack_i(ext_sc_ack_i), .grant_i(ext_sc_grant_i),
    .busy_o(busy), .req_o(ext_sc_req_o), .req_addr_o(ext_sc_addr_o),
    .done_o(sc_done_o), .success_o(sc_success_o));

  generate
    if (EXT_EN) begin : g_ll_notify
      always_ff @(posedge clk) begin
        if (rst) begin
          ext_ll_req_o  <= 1'b0;
          ext_ll_addr_o <= '0;
        end else begin
          ext_ll_req_o <= ll_take;
          if (ll_take) ext_ll_addr_o <= ll_addr_i;
        end
      end

      AST_LL_NOTIFY: assert property (@(posedge clk) disable iff (rst)
        (ll_valid_i && !sc_valid_i && !ext_sc_req_o) |=> (ext_ll_req_o && ext_ll_addr_o == $past(ll_addr_i)))
        else $error("missing link notification"); // R3
    end else begin : g_ll_silent
      assign ext_ll_req_o  = 1'b0;
      assign ext_ll_addr_o = '0;
    end
  endgenerate

  AST_LL_SETS: assert property (@(posedge clk) disable iff (rst)
    (ll_valid_i && !sc_valid_i && !ext_sc_req_o) |=> link_vld) else $error("link not set"); // R2
  AST_ERET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (eret_i && !ll_valid_i) |=> !link_vld) else $error("eret kept link"); // R7
  AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (rst)
    (sc_valid_i && !ext_sc_req_o) |=> !link_vld) else $error("sc kept link"); // R7
endmodule

// File: tb/llsc_resv_unit_tb.sv
module llsc_resv_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 32;
  localparam int LB  = 32;
  localparam int OFS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ll_v = 0, sc_v = 0, inv_v = 0, eret = 0, ack = 0, grant = 0;
  logic [AW-1:0] ll_a = '0, sc_a = '0, inv_a = '0;

  logic          llr [2];
  logic [AW-1:0] lla [2];
  logic          scr [2];
  logic [AW-1:0] sca [2];
  logic          dn  [2];
  logic          sx  [2];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_resv_unit #(.ADDR_W(AW), .LINE_BYTES(LB), .EXT_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst),
    .ll_valid_i(ll_v), .ll_addr_i(ll_a), .sc_valid_i(sc_v), .sc_addr_i(sc_a),
    .inval_valid_i(inv_v), .inval_addr_i(inv_a), .eret_i(eret),
    .ext_ll_req_o(llr[0]), .ext_ll_addr_o(lla[0]),
    .ext_sc_req_o(scr[0]), .ext_sc_addr_o(sca[0]),
    .ext_sc_ack_i(ack), .ext_sc_grant_i(grant),
    .sc_done_o(dn[0]), .sc_success_o(sx[0]));

  llsc_resv_unit #(.ADDR_W(AW), .LINE_BYTES(LB), .EXT_EN(1'b0)) u_dut_noext (
    .clk(clk), .rst(rst),
    .ll_valid_i(ll_v), .ll_addr_i(ll_a), .sc_valid_i(sc_v), .sc_addr_i(sc_a),
    .inval_valid_i(inv_v), .inval_addr_i(inv_a), .eret_i(eret),
    .ext_ll_req_o(llr[1]), .ext_ll_addr_o(lla[1]),
    .ext_sc_req_o(scr[1]), .ext_sc_addr_o(sca[1]),
    .ext_sc_ack_i(ack), .ext_sc_grant_i(grant),
    .sc_done_o(dn[1]), .sc_success_o(sx[1]));

  // reference model state, index 0 = interface enabled, 1 = disabled
  bit          m_vld [2];
  bit [AW-1:0] m_adr [2];
  bit          m_wait[2];
  bit          e_llr [2];
  bit [AW-1:0] e_lla [2];
  bit          e_scr [2];
  bit [AW-1:0] e_sca [2];
  bit          e_dn  [2];
  bit          e_sx  [2];

  function automatic bit same_line(input bit [AW-1:0] a, input bit [AW-1:0] b);
    return (a >> OFS) == (b >> OFS);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_vld[i] = 0; m_adr[i] = '0; m_wait[i] = 0;
      e_llr[i] = 0; e_lla[i] = '0; e_scr[i] = 0; e_sca[i] = '0;
      e_dn[i] = 0; e_sx[i] = 0;
    end
  endtask

  task automatic model_next();
    for (int i = 0; i < 2; i++) begin
      bit ext, hit_inv, eff;
      ext = (i == 0);
      hit_inv = inv_v && same_line(inv_a, m_adr[i]);
      eff = m_vld[i] && !eret && !hit_inv;
      e_llr[i] = 0; e_dn[i] = 0; e_sx[i] = 0;
      if (eret || hit_inv) m_vld[i] = 0;
      if (m_wait[i]) begin
        if (ack) begin
          m_wait[i] = 0; e_scr[i] = 0; e_dn[i] = 1; e_sx[i] = grant;
        end
      end else if (sc_v) begin
        m_vld[i] = 0;
        if (eff && same_line(sc_a, m_adr[i])) begin
          if (ext) begin
            m_wait[i] = 1; e_scr[i] = 1; e_sca[i] = sc_a;
          end else begin
            e_dn[i] = 1; e_sx[i] = 1;
          end
        end else begin
          e_dn[i] = 1; e_sx[i] = 0;
        end
      end else if (ll_v) begin
        m_vld[i] = 1; m_adr[i] = ll_a;
        if (ext) begin
          e_llr[i] = 1; e_lla[i] = ll_a;
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    for (int i = 0; i < 2; i++) begin
      chk(llr[i] == e_llr[i], {tag, " ll_req"}, AW'(llr[i]), AW'(e_llr[i]));
      if (e_llr[i]) chk(lla[i] == e_lla[i], {tag, " ll_addr"}, lla[i], e_lla[i]);
      chk(scr[i] == e_scr[i], {tag, " sc_req"}, AW'(scr[i]), AW'(e_scr[i]));
      if (e_scr[i]) chk(sca[i] == e_sca[i], {tag, " sc_addr"}, sca[i], e_sca[i]);
      chk(dn[i] == e_dn[i], {tag, " done"}, AW'(dn[i]), AW'(e_dn[i]));
      chk(sx[i] == e_sx[i], {tag, " success"}, AW'(sx[i]), AW'(e_sx[i]));
    end
  endtask

  task automatic step(input string tag,
                      input bit l, input bit [AW-1:0] la,
                      input bit s, input bit [AW-1:0] sa,
                      input bit iv, input bit [AW-1:0] ia,
                      input bit er, input bit ak, input bit gr);
    @(negedge clk);
    ll_v = l; ll_a = la; sc_v = s; sc_a = sa; inv_v = iv; inv_a = ia;
    eret = er; ack = ak; grant = gr;
    model_next();
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, '0, 0, '0, 0, '0, 0, 0, 0);
  endtask

  localparam bit [AW-1:0] LA = 32'h0000_1040;
  localparam bit [AW-1:0] LBX = 32'h0000_2080;

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    @(negedge clk);
    rst = 0;

    // R2 R3 R4 R5 R10: link then store-conditional at another offset of the line
    step("R3 ll notify", 1, LA, 0, '0, 0, '0, 0, 0, 0);
    step("R2 R10 sc same line", 0, '0, 1, LA + 32'd28, 0, '0, 0, 0, 0);
    step("R4 request held", 0, '0, 0, '0, 0, '0, 0, 0, 0);
    step("R5 grant go", 0, '0, 0, '0, 0, '0, 0, 1, 1);
    idle("R5 done one cycle");

    // R6: no link, then wrong line
    step("R6 no link", 0, '0, 1, LA, 0, '0, 0, 0, 0);
    step("R6 link", 1, LA, 0, '0, 0, '0, 0, 0, 0);
    step("R6 other line", 0, '0, 1, LBX, 0, '0, 0, 0, 0);
    step("R7 sc consumed link", 0, '0, 1, LA, 0, '0, 0, 0, 0);

    // R7: invalidations
    step("R7 link", 1, LA, 0, '0, 0, '0, 0, 0, 0);
    step("R7 inval other line", 0, '0, 0, '0, 1, LBX, 0, 0, 0);
    step("R7 inval linked line", 0, '0, 0, '0, 1, LA + 32'd4, 0, 0, 0);
    step("R7 sc after inval", 0, '0, 1, LA, 0, '0, 0, 0, 0);
    step("R7 link", 1, LA, 0, '0, 0, '0, 0, 0, 0);
    step("R7 eret", 0, '0, 0, '0, 0, '0, 1, 0, 0);
    step("R7 sc after eret", 0, '0, 1, LA, 0, '0, 0, 0, 0);
    step("R7 link", 1, LA, 0, '0, 0, '0, 0, 0, 0);
    step("R7 sc with eret same cycle", 0, '0, 1, LA, 0, '0, 1, 0, 0);
    step("R7 link", 1, LA, 0, '0, 0, '0, 0, 0, 0);
    step("R7 sc with inval same cycle", 0, '0, 1, LA, 1, LA, 0, 0, 0);

    // R8: priorities
    step("R8 ll with inval and eret", 1, LA, 0, '0, 1, LA, 1, 0, 0);
    step("R8 sc beats ll", 1, LBX, 1, LA, 0, '0, 0, 0, 0);
    step("R8 ll ignored, ack no-go", 0, '0, 0, '0, 0, '0, 0, 1, 0);
    step("R8 no link from ignored ll", 0, '0, 1, LBX, 0, '0, 0, 0, 0);

    // R9: inputs ignored while waiting, stray ack
    step("R9 link", 1, LBX, 0, '0, 0, '0, 0, 0, 0);
    step("R9 sc issues", 0, '0, 1, LBX, 0, '0, 0, 0, 0);
    step("R9 ll while waiting", 1, LA, 0, '0, 0, '0, 0, 0, 0);
    step("R9 sc while waiting", 0, '0, 1, LA, 0, '0, 0, 0, 0);
    step("R5 no-go", 0, '0, 0, '0, 0, '0, 0, 1, 0);
    step("R9 stray ack", 0, '0, 0, '0, 0, '0, 0, 1, 1);
    step("R9 sc after stray ack", 0, '0, 1, LA, 0, '0, 0, 0, 0);

    // random mix over four lines
    for (int n = 0; n < 4000; n++) begin
      bit [AW-1:0] r1, r2, r3;
      int op;
      r1 = 32'h0000_4000 + ({30'b0, 2'($urandom)} << OFS) + 32'($urandom % LB);
      r2 = 32'h0000_4000 + ({30'b0, 2'($urandom)} << OFS) + 32'($urandom % LB);
      r3 = 32'h0000_4000 + ({30'b0, 2'($urandom)} << OFS) + 32'($urandom % LB);
      op = int'($urandom % 16);
      step("R2 random",
           op < 6, r1,
           (op >= 4) && (op < 10), r2,
           ($urandom % 8) == 0, r3,
           ($urandom % 16) == 0,
           ($urandom % 3) == 0, 1'($urandom));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule